// File: doc/BRIEF.md
# MDIO Extended Register Access Engine

This engine turns one logical PHY register access into the management-bus transactions that access needs. A requester presents a PHY address, a 16-bit register number, a read/write flag and 16-bit write data. Register numbers from 0 to 31 fit the management frame directly, so they become a single transaction. Larger numbers are reached through an indirect window: the engine programs the window control register, loads the target number into the address/data register, switches the control register to data mode, and then reads or writes the address/data register.

Downstream the block drives a single-transaction master that serialises the frames. The engine pulses a start strobe with the PHY address, the 5-bit register address, the direction and the write data. It then waits for the master's done pulse before it issues the next step. When the last step completes, the engine returns a one-cycle acknowledge, together with the read data if the request was a read.

Top module: `mdio_xreg_engine`

## Requirements
- R1: After reset `req_ready` is 1, while `ack` and `mi_start` are 0.
- R2: A request with a register number of 31 (0x001F) or less produces exactly one downstream transaction. That transaction carries the register number's low 5 bits, the request direction (`mi_wr`=1 for write) and the write data.
- R3: A request with a register number above 31 produces exactly four transactions. The first is a write of 0x001F to register 13.
- R4: The second indirect transaction writes the full 16-bit target register number to register 14.
- R5: The third indirect transaction writes 0x401F to register 13, which selects data mode.
- R6: The fourth indirect transaction accesses register 14 in the request's direction. A write carries the request's write data.
- R7: `mi_start` is a one-cycle pulse. Every start after the first of a sequence is raised in the cycle that follows the one in which `mi_done` was sampled high.
- R8: `mi_phy` equals the accepted request's PHY address for every transaction of the sequence.
- R9: `ack` is a one-cycle pulse in the cycle after `mi_done` is sampled for the final transaction. With it, `ack_rdata` holds the `mi_rdata` of that transaction for a read, and 0 for a write.
- R10: `req_ready` is 0 from the cycle after acceptance until the acknowledge. A `req_valid` raised while `req_ready` is 0 is ignored and causes no transaction.
- R11: Register number 0x001F takes the direct path and 0x0020 takes the indirect path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when req_ready is 1 |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_phy | input | 5 | PHY address of the request |
| req_reg | input | 16 | Register number to access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| ack_rdata | output | 16 | Read result, valid with ack |
| mi_start | output | 1 | Start one management transaction |
| mi_done | input | 1 | Management transaction complete |
| mi_phy | output | 5 | PHY address for the transaction |
| mi_reg | output | 5 | Register address for the transaction |
| mi_wr | output | 1 | Transaction direction, 1 = write |
| mi_wdata | output | 16 | Transaction write data |
| mi_rdata | input | 16 | Transaction read data, valid with mi_done |

## Verification
A request accepted at one clock edge raises `mi_start` so that it is sampled at the next edge. A done pulse sampled at edge d brings the next start at edge d+1 and, for the final step, the acknowledge at edge d+1 as well. The bench logs the cycle number of every sampled start, done and acknowledge in its own downstream model. It checks those cycle numbers against the offsets above for done latencies of one to three cycles, instead of sampling at a fixed delay. It then compares each logged transaction with fields it computes itself from the request.

// File: rtl/mdio_xreg_pkg.sv
package mdio_xreg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } xreg_state_e;

  // Highest register number reachable by a direct management frame
  localparam int unsigned DIRECT_LIMIT      = 31;
  // Indirect window registers
  localparam int unsigned WIN_CTRL_REG      = 13;
  localparam int unsigned WIN_DATA_REG      = 14;
  // Control words: address mode and data mode (no post increment)
  localparam logic [15:0] WIN_ADDR_MODE     = 16'h001F;
  localparam logic [15:0] WIN_DATA_MODE     = 16'h401F;
  localparam int unsigned INDIRECT_STEPS    = 4;
  localparam int unsigned STEP_W            = $clog2(INDIRECT_STEPS);

endpackage

// File: rtl/mdio_xreg_steps.sv
module mdio_xreg_steps
  import mdio_xreg_pkg::*;
#(
  parameter int unsigned REG_W    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MI_REG_W = 5
) (
  input  logic                direct,
  input  logic [STEP_W-1:0]   step,
  input  logic [REG_W-1:0]    tgt_reg,
  input  logic                tgt_wr,
  input  logic [DATA_W-1:0]   tgt_wdata,
  output logic [MI_REG_W-1:0] mi_reg,
  output logic                mi_wr,
  output logic [DATA_W-1:0]   mi_wdata
);

  // Register address of a step of the indirect sequence
  function automatic logic [MI_REG_W-1:0] win_reg(input logic [STEP_W-1:0] s);
    return s[0] ? MI_REG_W'(WIN_DATA_REG) : MI_REG_W'(WIN_CTRL_REG);
  endfunction

  // Data word of a step of the indirect sequence
  function automatic logic [DATA_W-1:0] win_data(input logic [STEP_W-1:0] s,
                                                 input logic [REG_W-1:0]  r,
                                                 input logic [DATA_W-1:0] d);
    case (s)
      2'd0:    return DATA_W'(WIN_ADDR_MODE);
      2'd1:    return DATA_W'(r);
      2'd2:    return DATA_W'(WIN_DATA_MODE);
      default: return d;
    endcase
  endfunction

  logic final_step;
  assign final_step = (step == STEP_W'(INDIRECT_STEPS - 1));

  always_comb begin
    if (direct) begin
      mi_reg   = tgt_reg[MI_REG_W-1:0];
      mi_wr    = tgt_wr;
      mi_wdata = tgt_wdata;
    end else begin
      mi_reg   = win_reg(step);
      mi_wr    = final_step ? tgt_wr : 1'b1;
      mi_wdata = win_data(step, tgt_reg, tgt_wdata);
    end
  end

endmodule

// File: rtl/mdio_xreg_ctrl.sv
module mdio_xreg_ctrl
  import mdio_xreg_pkg::*;
#(
  parameter int unsigned PHY_W  = 5,
  parameter int unsigned REG_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic              req_wr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              mi_done,
  input  logic [DATA_W-1:0] mi_rdata,
  output logic              mi_start,
  output logic [STEP_W-1:0] step,
  output logic              direct,
  output logic [PHY_W-1:0]  tgt_phy,
  output logic [REG_W-1:0]  tgt_reg,
  output logic              tgt_wr,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] ack_rdata
);

  function automatic logic fits_direct(input logic [REG_W-1:0] r);
    return r <= REG_W'(DIRECT_LIMIT);
  endfunction

  xreg_state_e state;
  logic        accept;
  logic        step_done;
  logic        last_step;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign mi_start  = (state == ST_ISSUE);
  assign step_done = (state == ST_WAIT) && mi_done;
  assign last_step = direct || (step == STEP_W'(INDIRECT_STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      step      <= '0;
      direct    <= 1'b1;
      tgt_phy   <= '0;
      tgt_reg   <= '0;
      tgt_wr    <= 1'b0;
      tgt_wdata <= '0;
      ack       <= 1'b0;
      ack_rdata <= '0;
    end else begin
      ack <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          tgt_phy   <= req_phy;
          tgt_reg   <= req_reg;
          tgt_wr    <= req_wr;
          tgt_wdata <= req_wdata;
          direct    <= fits_direct(req_reg);
          step      <= '0;
          state     <= ST_ISSUE;
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (step_done) begin
          if (last_step) begin
            ack       <= 1'b1;
            ack_rdata <= tgt_wr ? '0 : mi_rdata;
            step      <= '0;
            state     <= ST_IDLE;
          end else begin
            step  <= step + 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mi_start |=> !mi_start);

  p_start_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mi_start |-> ($past(mi_done) || $past(req_valid && req_ready)));

  p_ack_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(mi_done));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_direct_one_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mi_start && direct) |-> (step == '0));

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !step_done) |=> !req_ready);

endmodule

// File: rtl/mdio_xreg_engine.sv
module mdio_xreg_engine
  import mdio_xreg_pkg::*;
#(
  parameter int unsigned PHY_W    = 5,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MI_REG_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PHY_W-1:0]    req_phy,
  input  logic [REG_W-1:0]    req_reg,
  input  logic                req_wr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                ack,
  output logic [DATA_W-1:0]   ack_rdata,
  output logic                mi_start,
  input  logic                mi_done,
  output logic [PHY_W-1:0]    mi_phy,
  output logic [MI_REG_W-1:0] mi_reg,
  output logic                mi_wr,
  output logic [DATA_W-1:0]   mi_wdata,
  input  logic [DATA_W-1:0]   mi_rdata
);

  logic [STEP_W-1:0] step;
  logic              direct;
  logic [PHY_W-1:0]  tgt_phy;
  logic [REG_W-1:0]  tgt_reg;
  logic              tgt_wr;
  logic [DATA_W-1:0] tgt_wdata;

  mdio_xreg_ctrl #(.PHY_W(PHY_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .mi_done   (mi_done),
    .mi_rdata  (mi_rdata),
    .mi_start  (mi_start),
    .step      (step),
    .direct    (direct),
    .tgt_phy   (tgt_phy),
    .tgt_reg   (tgt_reg),
    .tgt_wr    (tgt_wr),
    .tgt_wdata (tgt_wdata),
    .ack       (ack),
    .ack_rdata (ack_rdata)
  );

  mdio_xreg_steps #(.REG_W(REG_W), .DATA_W(DATA_W), .MI_REG_W(MI_REG_W)) u_steps (
    .direct    (direct),
    .step      (step),
    .tgt_reg   (tgt_reg),
    .tgt_wr    (tgt_wr),
    .tgt_wdata (tgt_wdata),
    .mi_reg    (mi_reg),
    .mi_wr     (mi_wr),
    .mi_wdata  (mi_wdata)
  );

  assign mi_phy = tgt_phy;

  p_phy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mi_phy));

  p_ctrl_step_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mi_start && (mi_reg == MI_REG_W'(WIN_CTRL_REG)) && !direct) |-> mi_wr);

endmodule

// File: tb/mdio_xreg_engine_bench.sv
module mdio_xreg_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_wr, ack, mi_start, mi_done, mi_wr;
  logic [4:0]  req_phy, mi_phy, mi_reg;
  logic [15:0] req_reg, req_wdata, ack_rdata, mi_wdata, mi_rdata;

  always #5 clk = ~clk;

  mdio_xreg_engine u_mdio_xreg_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_phy(req_phy), .req_reg(req_reg), .req_wr(req_wr), .req_wdata(req_wdata),
    .ack(ack), .ack_rdata(ack_rdata), .mi_start(mi_start), .mi_done(mi_done),
    .mi_phy(mi_phy), .mi_reg(mi_reg), .mi_wr(mi_wr), .mi_wdata(mi_wdata),
    .mi_rdata(mi_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int n_log = 0;
  int lat = 1;
  int ack_t = 0;
  logic [4:0]  lg_phy [256];
  logic [4:0]  lg_reg [256];
  logic        lg_wr  [256];
  logic [15:0] lg_wd  [256];
  int          lg_st  [256];
  int          lg_dn  [256];
  int          dly = 0;
  logic        m_busy = 1'b0;
  logic [4:0]  m_reg = '0;

  // Downstream transaction model with a configurable done latency
  always @(posedge clk) begin
    cyc     <= cyc + 1;
    mi_done <= 1'b0;
    if (ack) ack_t <= cyc;
    if (mi_start) begin
      lg_phy[n_log] <= mi_phy;
      lg_reg[n_log] <= mi_reg;
      lg_wr[n_log]  <= mi_wr;
      lg_wd[n_log]  <= mi_wdata;
      lg_st[n_log]  <= cyc;
      n_log  <= n_log + 1;
      m_reg  <= mi_reg;
      dly    <= lat;
      m_busy <= 1'b1;
    end else if (m_busy) begin
      if (dly <= 1) begin
        mi_done  <= 1'b1;
        mi_rdata <= 16'hA5A5 ^ {8'(n_log - 1), 3'b000, m_reg};
        lg_dn[n_log-1] <= cyc;
        m_busy   <= 1'b0;
      end else dly <= dly - 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_reg(input int nsteps, input int k, input logic [15:0] r);
    if (nsteps == 1) return r[4:0];
    return (k % 2 == 0) ? 5'd13 : 5'd14;
  endfunction

  function automatic logic exp_wr(input int nsteps, input int k, input logic w);
    return (k == nsteps - 1) ? w : 1'b1;
  endfunction

  function automatic logic [15:0] exp_wd(input int nsteps, input int k, input logic [15:0] r,
                                        input logic [15:0] d);
    if (k == nsteps - 1) return d;
    if (k == 1) return r;
    return (k == 0) ? 16'h001F : 16'h401F;
  endfunction

  function automatic string step_req(input int nsteps, input int k);
    if (nsteps == 1) return "R2";
    case (k)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_req(input logic [4:0] p, input logic [15:0] r, input logic w,
                         input logic [15:0] d, input int l, input bit poke);
    int base;
    int nsteps;
    int waited;
    logic [15:0] exp_rd;
    base   = n_log;
    nsteps = (r <= 16'd31) ? 1 : 4;
    lat    = l;
    @(negedge clk);
    req_valid = 1'b1; req_phy = p; req_reg = r; req_wr = w; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready low while busy", 32'(req_ready), 32'd0);
    if (poke) begin
      req_valid = 1'b1; req_phy = 5'h1E; req_reg = 16'h0003; req_wr = 1'b1; req_wdata = 16'hDEAD;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waited = 0;
    while (!ack && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    chk(ack == 1'b1, "R9 ack seen", 32'(ack), 32'd1);
    exp_rd = w ? 16'h0000
               : (16'hA5A5 ^ {8'(base + nsteps - 1), 3'b000, (nsteps == 1) ? r[4:0] : 5'd14});
    chk(ack_rdata == exp_rd, "R9 ack data", 32'(ack_rdata), 32'(exp_rd));
    @(negedge clk);
    chk(ack == 1'b0, "R9 ack one cycle", 32'(ack), 32'd0);
    repeat (4) @(negedge clk);
    chk(n_log - base == nsteps,
        (r == 16'h001F || r == 16'h0020) ? "R11 transaction count" :
        (poke ? "R10 ignored request count" : "R2/R3 transaction count"),
        32'(n_log - base), 32'(nsteps));
    chk(ack_t == lg_dn[base + nsteps - 1] + 2, "R9 ack timing",
        32'(ack_t), 32'(lg_dn[base + nsteps - 1] + 2));
    for (int k = 0; k < nsteps; k++) begin
      chk(lg_reg[base+k] == exp_reg(nsteps, k, r), step_req(nsteps, k),
          32'(lg_reg[base+k]), 32'(exp_reg(nsteps, k, r)));
      chk(lg_wr[base+k] == exp_wr(nsteps, k, w), step_req(nsteps, k),
          32'(lg_wr[base+k]), 32'(exp_wr(nsteps, k, w)));
      if (exp_wr(nsteps, k, w))
        chk(lg_wd[base+k] == exp_wd(nsteps, k, r, d), step_req(nsteps, k),
            32'(lg_wd[base+k]), 32'(exp_wd(nsteps, k, r, d)));
      chk(lg_phy[base+k] == p, "R8 phy held", 32'(lg_phy[base+k]), 32'(p));
      if (k > 0)
        chk(lg_st[base+k] == lg_dn[base+k-1] + 2, "R7 step after done",
            32'(lg_st[base+k]), 32'(lg_dn[base+k-1] + 2));
    end
  endtask

  logic [15:0] regs [7] = '{16'h0000, 16'h0001, 16'h001F, 16'h0020, 16'h0031, 16'h00D3, 16'hFFFF};
  logic [4:0]  phys [4] = '{5'h01, 5'h03, 5'h0C, 5'h0F};

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_phy = '0; req_reg = '0; req_wr = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
    chk(ack == 1'b0, "R1 ack after reset", 32'(ack), 32'd0);
    chk(mi_start == 1'b0, "R1 start after reset", 32'(mi_start), 32'd0);
    for (int i = 0; i < 7; i++) begin
      for (int w = 0; w < 2; w++) begin
        run_req(phys[(i + w) % 4], regs[i], w[0], 16'h1234 ^ 16'(i * 257 + w * 4097),
                1 + (i + w) % 3, (i == 4) && (w == 0));
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule